// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a set of external input lines and turns selected signal edges into interrupt requests and event pulses. Software decides, one line at a time, whether a rising edge, a falling edge or both count as a trigger. A trigger on a line whose interrupt mask is set latches a sticky pending flag. The single interrupt output is the OR of all pending flags. A trigger on a line whose event mask is set produces a one-cycle pulse on that line's event output.

Inputs may be asynchronous. Each line passes through a two-stage synchronizer, and edges are found on the synchronized value. Software reaches the block through a flat 32-bit register port. Reads are combinational on the byte address. A write takes effect on the clock edge where the write enable is high. The pending register is cleared by writing ones to it.

Writes to the trigger registers race with incoming edges, and the two polarities resolve that race differently. For a rising edge in the cycle of a rising-select write, the line counts as enabled if either the old or the new select value enables it. A falling edge in the cycle of a falling-select write is dropped on every line.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x0000_0000, `irq_o` is low and `evt_o` is all zeros.
- R2: The register map by byte address is: interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, pending 0x14. Any other address reads zero. Bit n of each register belongs to line n.
- R3: When the rising-select bit of a line is 1, a low-to-high change on its input sets the line's pending bit on the third rising clock edge after the change. A high-to-low change then has no effect unless falling select is also set.
- R4: When the falling-select bit of a line is 1, a high-to-low change on its input sets the pending bit with the same three-edge latency.
- R5: With both select bits set on a line, either edge direction triggers it. With neither set, no edge sets a pending bit or pulses an event.
- R6: A trigger sets the pending bit only if the line's interrupt-mask bit is 1. It raises the line's event output for exactly one cycle, in the same cycle the pending bit would set, only if the event-mask bit is 1.
- R7: A rising edge on a line, detected in the same cycle as a write to the rising-select register, sets the pending bit when either the old or the newly written value enables that line.
- R8: A falling edge detected in the same cycle as a write to the falling-select register sets no pending bit and no event.
- R9: Bits 31:23 of every register read zero and ignore writes of ones.
- R10: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a trigger lands in the same cycle as the clear, the bit stays set.
- R11: `irq_o` is high exactly when at least one pending bit is set. It stays high until software has cleared every pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lines_in | input | 23 | External lines, may be asynchronous |
| addr | input | 5 | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | OR of all pending bits |
| evt_o | output | 23 | One-cycle event pulse per line |

## Verification
A corrupted synchronizer or edge history shows up at the ports as a pending bit that sets one cycle early or late, or on the wrong polarity. The sweep catches this because it samples exactly three clock edges after every input change, for every line under all four select combinations and both edge directions. A wrong pending or mask state shows at once in the pending read-back and in `irq_o`. An event pulse that is stretched or misplaced shows in the cycle right after the expected pulse. The two write-collision rules are driven cycle-exact, so a collision resolved the wrong way shows as a pending bit that differs from the expected value on the very next read.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NLINES = 23,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lines_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq_o,
  output logic [NLINES-1:0] evt_o
);
  localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_RSEL  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_FSEL  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(8'h14);

  logic [NLINES-1:0] imask, emask, rsel, fsel, pend;
  logic [NLINES-1:0] meta, sync, hist;
  logic [NLINES-1:0] rise, fall, trig, clr;
  logic [NLINES-1:0] wdat;
  logic              w_im, w_em, w_rs, w_fs, w_pd;

  assign wdat = wr_data[NLINES-1:0];
  assign w_im = wr_en && addr == A_IMASK;
  assign w_em = wr_en && addr == A_EMASK;
  assign w_rs = wr_en && addr == A_RSEL;
  assign w_fs = wr_en && addr == A_FSEL;
  assign w_pd = wr_en && addr == A_PEND;

  // synchronizer plus one cycle of history for edge detection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
      hist <= '0;
    end else begin
      meta <= lines_in;
      sync <= meta;
      hist <= sync;
    end

  assign rise = sync & ~hist;
  assign fall = ~sync & hist;

  // rising: old or new select counts during a write; falling: dropped during a write
  assign trig = (rise & (rsel | (w_rs ? wdat : '0)))
              | (fall & (w_fs ? '0 : fsel));
  assign clr  = w_pd ? wdat : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      imask <= '0;
      emask <= '0;
      rsel  <= '0;
      fsel  <= '0;
      pend  <= '0;
      evt_o <= '0;
    end else begin
      if (w_im) imask <= wdat;
      if (w_em) emask <= wdat;
      if (w_rs) rsel  <= wdat;
      if (w_fs) fsel  <= wdat;
      pend  <= (pend & ~clr) | (trig & imask);
      evt_o <= trig & emask;
    end

  assign irq_o = |pend;

  always_comb begin
    rd_data = '0;
    case (addr)
      A_IMASK: rd_data[NLINES-1:0] = imask;
      A_EMASK: rd_data[NLINES-1:0] = emask;
      A_RSEL:  rd_data[NLINES-1:0] = rsel;
      A_FSEL:  rd_data[NLINES-1:0] = fsel;
      A_PEND:  rd_data[NLINES-1:0] = pend;
      default: rd_data = '0;
    endcase
  end

  AST_NO_EDGE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rise == '0 && fall == '0) |=> (pend & ~$past(pend)) == '0); // R5
  AST_EVT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_o & ~$past(emask)) == '0); // R6
  AST_FALL_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (w_fs && rise == '0) |=> (pend & ~$past(pend)) == '0 && evt_o == '0); // R8
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(pend) & ~$past(clr) & ~pend) == '0); // R10
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !w_pd) |=> irq_o); // R11
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  localparam int N = 23;
  localparam logic [31:0] ALL = 32'h007F_FFFF;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  lines_in = '0;
  logic [4:0]    addr = '0;
  logic          wr_en = 0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          irq_o;
  logic [N-1:0]  evt_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl u_dut (.clk, .rst_n, .lines_in, .addr, .wr_en, .wr_data,
                      .rd_data, .irq_o, .evt_o);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #1 d = rd_data;
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R2 map
    foreach (d[i]) ;
    for (int a = 0; a < 32; a += 4) begin
      rd(a[4:0], d); check("R1", d, 0);
    end
    check("R1", {31'd0, irq_o}, 0);
    check("R1", evt_o, 0);

    // R9 reserved bits, R2 offsets
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, d); check("R9", d, ALL);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); check("R9", d, ALL);
    wr(5'h08, 32'hA5A5_A5A5); rd(5'h08, d); check("R9", d, 32'hA5A5_A5A5 & ALL);
    wr(5'h0C, 32'h5A5A_5A5A); rd(5'h0C, d); check("R9", d, 32'h5A5A_5A5A & ALL);
    rd(5'h10, d); check("R2", d, 0);
    rd(5'h18, d); check("R2", d, 0);

    // R3 R4 R5 R6 R11 sweep: every line, every select combo, both edges
    for (int ln = 0; ln < N; ln++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic [31:0] bit_m;
        bit_m = 32'd1 << ln;
        wr(5'h08, cfg[0] ? bit_m : 0);
        wr(5'h0C, cfg[1] ? bit_m : 0);
        lines_in[ln] = 1;
        repeat (2) @(negedge clk);
        rd(5'h14, d); check("R3", d, 0);
        @(negedge clk);
        rd(5'h14, d); check("R3", d, cfg[0] ? bit_m : 0);
        check("R6", evt_o, cfg[0] ? bit_m : 0);
        check("R11", {31'd0, irq_o}, {31'd0, cfg[0]});
        @(negedge clk);
        check("R6", evt_o, 0);
        wr(5'h14, ALL);
        rd(5'h14, d); check("R10", d, 0);
        lines_in[ln] = 0;
        repeat (3) @(negedge clk);
        rd(5'h14, d); check("R4", d, cfg[1] ? bit_m : 0);
        check("R5", evt_o, cfg[1] ? bit_m : 0);
        wr(5'h14, ALL);
        check("R11", {31'd0, irq_o}, 0);
      end
    end

    // R6 interrupt mask off: event only; event mask off: pending only
    wr(5'h08, 32'h1); wr(5'h0C, 0);
    wr(5'h00, 0);
    lines_in[0] = 1; repeat (3) @(negedge clk);
    rd(5'h14, d); check("R6", d, 0);
    check("R6", evt_o, 1);
    lines_in[0] = 0; repeat (3) @(negedge clk);
    wr(5'h00, ALL); wr(5'h04, 0);
    lines_in[0] = 1; repeat (3) @(negedge clk);
    rd(5'h14, d); check("R6", d, 1);
    check("R6", evt_o, 0);
    wr(5'h04, ALL);

    // R10: write 0 no effect, clear of other bits keeps this one
    wr(5'h14, 0); rd(5'h14, d); check("R10", d, 1);
    wr(5'h14, 32'h2); rd(5'h14, d); check("R10", d, 1);
    // R11: two pending, clear one, irq stays
    wr(5'h08, 32'h3);
    lines_in[1] = 1; repeat (3) @(negedge clk);
    rd(5'h14, d); check("R11", d, 3);
    wr(5'h14, 32'h1); check("R11", {31'd0, irq_o}, 1);
    wr(5'h14, 32'h2); check("R11", {31'd0, irq_o}, 0);
    lines_in[0] = 0; lines_in[1] = 0; repeat (3) @(negedge clk);

    // R10: trigger in same cycle as clear keeps bit
    wr(5'h08, 32'h4);
    lines_in[2] = 1; repeat (3) @(negedge clk);
    lines_in[2] = 0; repeat (3) @(negedge clk);
    lines_in[2] = 1; repeat (2) @(negedge clk);
    wr(5'h14, 32'h4);
    rd(5'h14, d); check("R10", d, 4);
    wr(5'h14, ALL);
    lines_in[2] = 0; repeat (3) @(negedge clk);

    // R7: rising edge during rising-select write enabling the line
    wr(5'h08, 0); wr(5'h0C, 0);
    lines_in[5] = 1; repeat (2) @(negedge clk);
    wr(5'h08, 32'h20);
    rd(5'h14, d); check("R7", d, 32'h20);
    wr(5'h14, ALL);
    // R7: old value enables, write disables: still set
    lines_in[5] = 0; repeat (3) @(negedge clk);
    lines_in[5] = 1; repeat (2) @(negedge clk);
    wr(5'h08, 0);
    rd(5'h14, d); check("R7", d, 32'h20);
    wr(5'h14, ALL);

    // R8: falling edge during falling-select write is dropped
    wr(5'h0C, 32'h20);
    lines_in[5] = 0; repeat (2) @(negedge clk);
    wr(5'h0C, 32'h20);
    rd(5'h14, d); check("R8", d, 0);
    check("R8", evt_o, 0);
    // R8 contrast: same edge without write is caught
    lines_in[5] = 1; repeat (3) @(negedge clk);
    lines_in[5] = 0; repeat (3) @(negedge clk);
    rd(5'h14, d); check("R8", d, 32'h20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule